// File: doc/BRIEF.md
# Synchronous Peripheral Bus Cycle Sequencer

This block sits on the processor side of a bus. It runs bus cycles that target slow peripherals of the older synchronous kind, which are paced by a shared enable clock and cannot answer with an asynchronous handshake. It divides the system clock into a free-running enable clock `e_clk`. The enable clock runs all the time, whether the bus is busy or idle. An address decoder marks a peripheral access by pulling `vpa_n` low while the address strobe `as_n` is low.

When that happens, the sequencer waits for a fixed point in the low phase of `e_clk`. It then drives the peripheral enable `vma_n` low and keeps it low through the next high phase of `e_clk`, which is when the transfer happens. For a read, it pulses `latch_stb` in the last high cycle so that data is captured as `e_clk` falls. It raises `cyc_done` for one cycle once `e_clk` is low again, and it releases `vma_n` one clock after that.

If the address strobe is withdrawn before `vma_n` has been asserted, the access is abandoned and `vma_n` never goes low. All pins are plain level or pulse controls. There is no streamed data path, so no valid/ready handshake and no back-pressure apply.

Top module: `sync_periph_seq`

## Requirements
- R1: `e_clk` repeats every `E_DIV` system clocks (default 10). Within each period it is low for `E_DIV-E_HIGH` clocks (default 6) and then high for `E_HIGH` clocks (default 4). It runs regardless of bus activity.
- R2: While `rst_n` is low: `e_clk` is low, `vma_n` is high, and `cyc_done` and `latch_stb` are low. After release, the first rising edge of `e_clk` comes `E_DIV-E_HIGH` clocks later.
- R3: An access starts only when, at a clock edge, `as_n` is 0, `vpa_n` is 0 and at least one of `uds_n` and `lds_n` is 0. With `vpa_n` high, or with both data strobes high, `vma_n` stays high.
- R4: Number the clocks of each `e_clk` period 0 to `E_DIV-1`, with 0 being the first low clock after `e_clk` falls. `vma_n` goes low on the first edge after the start condition that enters clock `E_DIV-E_HIGH-VMA_LEAD` (default 3), which lies in the low phase. It then stays low through the whole following high phase.
- R5: In a read access (`rw_n`=1), `latch_stb` is high for exactly the last high clock of `e_clk`, so that data is taken as `e_clk` falls. A write access (`rw_n`=0) produces no `latch_stb`.
- R6: `cyc_done` is a one-clock pulse in clock 0 right after that falling edge. `vma_n` returns high one clock later.
- R7: If `as_n` is high at an edge while the sequencer is still waiting for alignment, the access is dropped and `vma_n` stays high.
- R8: After `cyc_done`, no new access starts until `as_n` has been seen high, even if `as_n`, `vpa_n` and the strobes stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | Address strobe, active low |
| rw_n | input | 1 | 1 = read, 0 = write |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| vpa_n | input | 1 | Decoder flag for a synchronous peripheral, active low |
| e_clk | output | 1 | Divided peripheral enable clock |
| vma_n | output | 1 | Peripheral enable, active low |
| cyc_done | output | 1 | One-clock end-of-access pulse |
| latch_stb | output | 1 | Read data capture strobe |

## Verification
The bench builds the block with its defaults: a divide by 10 with 4 high clocks and a 3-clock lead, so `vma_n` falls at clock 3. These small values keep a whole `e_clk` period within a dozen clocks. Random request arrival times can therefore land on every phase, including the one clock just before the alignment point, where the access skips the wait. They also reach the case that misses the point and waits almost a full period. The short periods let aborts, held address strobes, writes and requests without a peripheral flag all fit within a few thousand clocks.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ACTIVE,
    ST_DONE,
    ST_RELEASE
  } seq_state_t;
endpackage

// File: rtl/sps_eclk_gen.sv
module sps_eclk_gen #(
  parameter int PERIOD = 10,
  parameter int HIGH   = 4,
  localparam int PW    = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          e_clk
);
  localparam int LOW = PERIOD - HIGH;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] phase_nxt;

  always_comb begin
    if (phase == LAST) phase_nxt = '0;
    else               phase_nxt = phase + 1'b1;
  end

  // e_clk is registered from the next phase so that it lines up with phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      e_clk <= 1'b0;
    end else begin
      phase <= phase_nxt;
      e_clk <= (phase_nxt >= PW'(LOW));
    end
  end
endmodule

// File: rtl/sps_req_qual.sv
module sps_req_qual (
  input  logic as_n,
  input  logic vpa_n,
  input  logic uds_n,
  input  logic lds_n,
  output logic req
);
  // a peripheral access needs the address strobe, the decoder flag and a data strobe
  always_comb req = !as_n && !vpa_n && (!uds_n || !lds_n);
endmodule

// File: rtl/sps_ctrl_fsm.sv
module sps_ctrl_fsm
  import sps_pkg::*;
#(
  parameter int PERIOD = 10,
  parameter int VMA_PH = 3,
  localparam int PW    = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          as_n,
  input  logic          rw_n,
  input  logic [PW-1:0] phase,
  output logic          vma_n,
  output logic          latch_stb,
  output logic          cyc_done
);
  localparam logic [PW-1:0] ARM_PH   = PW'(VMA_PH - 1);
  localparam logic [PW-1:0] LATCH_PH = PW'(PERIOD - 2);
  localparam logic [PW-1:0] END_PH   = PW'(PERIOD - 1);

  seq_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      vma_n     <= 1'b1;
      latch_stb <= 1'b0;
      cyc_done  <= 1'b0;
    end else begin
      latch_stb <= 1'b0;
      cyc_done  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            if (phase == ARM_PH) begin
              state <= ST_ACTIVE;
              vma_n <= 1'b0;
            end else begin
              state <= ST_ALIGN;
            end
          end
        end
        ST_ALIGN: begin
          if (as_n) begin
            state <= ST_IDLE;
          end else if (phase == ARM_PH) begin
            state <= ST_ACTIVE;
            vma_n <= 1'b0;
          end
        end
        ST_ACTIVE: begin
          if (phase == LATCH_PH) latch_stb <= rw_n;
          if (phase == END_PH) begin
            cyc_done <= 1'b1;
            state    <= ST_DONE;
          end
        end
        ST_DONE: begin
          vma_n <= 1'b1;
          state <= ST_RELEASE;
        end
        ST_RELEASE: begin
          if (as_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sync_periph_seq.sv
module sync_periph_seq #(
  parameter int E_DIV    = 10,
  parameter int E_HIGH   = 4,
  parameter int VMA_LEAD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  input  logic rw_n,
  input  logic uds_n,
  input  logic lds_n,
  input  logic vpa_n,
  output logic e_clk,
  output logic vma_n,
  output logic cyc_done,
  output logic latch_stb
);
  localparam int PW     = $clog2(E_DIV);
  localparam int VMA_PH = E_DIV - E_HIGH - VMA_LEAD;

  logic [PW-1:0] phase;
  logic          req;

  sps_eclk_gen #(.PERIOD(E_DIV), .HIGH(E_HIGH)) u_eclk (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase),
    .e_clk (e_clk)
  );

  sps_req_qual u_qual (
    .as_n  (as_n),
    .vpa_n (vpa_n),
    .uds_n (uds_n),
    .lds_n (lds_n),
    .req   (req)
  );

  sps_ctrl_fsm #(.PERIOD(E_DIV), .VMA_PH(VMA_PH)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .as_n      (as_n),
    .rw_n      (rw_n),
    .phase     (phase),
    .vma_n     (vma_n),
    .latch_stb (latch_stb),
    .cyc_done  (cyc_done)
  );
endmodule

// File: rtl/sync_periph_seq_chk.sv
module sync_periph_seq_chk #(
  parameter int E_DIV  = 10,
  parameter int E_HIGH = 4
) (
  input logic clk,
  input logic rst_n,
  input logic as_n,
  input logic e_clk,
  input logic vma_n,
  input logic cyc_done,
  input logic latch_stb
);
  logic [7:0] hi_run;
  logic [7:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= e_clk ? hi_run + 8'd1 : 8'd0;
      lo_run <= e_clk ? 8'd0 : lo_run + 8'd1;
    end
  end

  // R1: high phase length
  p_e_high_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_clk) |-> hi_run == 8'(E_HIGH));

  // R1, R2: low phase length, including the first one after reset
  p_e_low_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_clk) |-> lo_run == 8'(E_DIV - E_HIGH));

  // R4: enable is asserted only inside the low phase
  p_vma_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vma_n) |-> !e_clk);

  // R5: capture strobe is the last high clock
  p_latch_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> $fell(e_clk));

  // R5, R6: read capture is followed by the end pulse
  p_done_after_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> cyc_done);

  // R6: one-clock end pulse, then enable released
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> (!cyc_done && $rose(vma_n)));

  // R7: no enable while the address strobe is withdrawn
  p_abort_no_vma_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n && vma_n) |=> vma_n);
endmodule

bind sync_periph_seq sync_periph_seq_chk #(.E_DIV(E_DIV), .E_HIGH(E_HIGH)) u_chk (.*);

// File: tb/sync_periph_seq_tb.sv
`timescale 1ns/1ps
module sync_periph_seq_tb;
  localparam int E_DIV    = 10;
  localparam int E_HIGH   = 4;
  localparam int VMA_LEAD = 3;
  localparam int VMA_PH   = E_DIV - E_HIGH - VMA_LEAD;
  localparam int S_IDLE = 0, S_ALIGN = 1, S_ACT = 2, S_DONE = 3, S_REL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, rw_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, vpa_n = 1'b1;
  logic e_clk, vma_n, cyc_done, latch_stb;

  int    n_cmp = 0;
  int    n_bad = 0;
  string vtag  = "R4";
  bit    chk_en = 1'b0;

  always #2.5 clk = ~clk;

  sync_periph_seq #(.E_DIV(E_DIV), .E_HIGH(E_HIGH), .VMA_LEAD(VMA_LEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw_n(rw_n), .uds_n(uds_n),
    .lds_n(lds_n), .vpa_n(vpa_n), .e_clk(e_clk), .vma_n(vma_n),
    .cyc_done(cyc_done), .latch_stb(latch_stb)
  );

  // expected behaviour, built from the requirements
  int m_ph, m_st;
  bit m_e, m_vma_n, m_done, m_latch;

  function automatic bit start_f(logic a, logic v, logic u, logic l);
    return !a && !v && (!u || !l);
  endfunction

  function automatic int next_ph(int p);
    return (p == E_DIV - 1) ? 0 : p + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_e <= 1'b0; m_st <= S_IDLE;
      m_vma_n <= 1'b1; m_done <= 1'b0; m_latch <= 1'b0;
    end else begin
      m_ph <= next_ph(m_ph);
      m_e  <= (next_ph(m_ph) >= E_DIV - E_HIGH);
      m_done  <= 1'b0;
      m_latch <= 1'b0;
      case (m_st)
        S_IDLE:
          if (start_f(as_n, vpa_n, uds_n, lds_n)) begin
            if (next_ph(m_ph) == VMA_PH) begin m_st <= S_ACT; m_vma_n <= 1'b0; end
            else m_st <= S_ALIGN;
          end
        S_ALIGN:
          if (as_n) m_st <= S_IDLE;
          else if (next_ph(m_ph) == VMA_PH) begin m_st <= S_ACT; m_vma_n <= 1'b0; end
        S_ACT: begin
          if (next_ph(m_ph) == E_DIV - 1) m_latch <= rw_n;
          if (next_ph(m_ph) == 0) begin m_done <= 1'b1; m_st <= S_DONE; end
        end
        S_DONE: begin m_vma_n <= 1'b1; m_st <= S_REL; end
        default: if (as_n) m_st <= S_IDLE;
      endcase
    end
  end

  task automatic check(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check("R1", e_clk, m_e);
      check(vtag, vma_n, m_vma_n);
      check("R5", latch_stb, m_latch);
      check("R6", cyc_done, m_done);
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // one access: drive, wait for the end pulse or the abort point, hold, release
  task automatic access(bit rw, bit u, bit l, bit vpa, int abort_at, int hold);
    as_n = 1'b0; rw_n = rw; uds_n = u; lds_n = l; vpa_n = vpa;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (m_done) break;
      if (i == abort_at) break;
    end
    repeat (hold) @(negedge clk);
    as_n = 1'b1; vpa_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int k;
    bit saw_vma;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R2: reset values
    check("R2", e_clk, 1'b0);
    check("R2", vma_n, 1'b1);
    check("R2", cyc_done, 1'b0);
    check("R2", latch_stb, 1'b0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    // R2: first rise of e_clk after release
    k = 0;
    while (!e_clk && k < 50) begin @(negedge clk); k++; end
    check_int("R2", k, E_DIV - E_HIGH);
    repeat (25) @(negedge clk);   // R1: free-running while idle

    // R4, R5: read and write with both strobes
    access(1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
    access(1'b0, 1'b0, 1'b1, 1'b0, 0, 1);

    // R3: no peripheral flag, then no data strobe
    vtag = "R3";
    saw_vma = 1'b0;
    fork
      access(1'b1, 1'b0, 1'b0, 1'b1, 0, 0);
      repeat (40) begin @(negedge clk); if (!vma_n) saw_vma = 1'b1; end
    join
    check("R3", saw_vma, 1'b0);
    access(1'b1, 1'b1, 1'b1, 1'b0, 25, 0);

    // R7: abort while waiting for alignment
    vtag = "R7";
    while (!e_clk) @(negedge clk);
    access(1'b1, 1'b0, 1'b0, 1'b0, 2, 0);
    check("R7", vma_n, 1'b1);

    // R8: strobe held low long after the end pulse
    vtag = "R8";
    access(1'b1, 1'b1, 1'b0, 1'b0, 0, 15);
    vtag = "R4";

    // random traffic
    for (int n = 0; n < 120; n++) begin
      int gap = $urandom_range(0, 9);
      repeat (gap) @(negedge clk);
      access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), ($urandom_range(0, 4) == 0),
             (($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 12)) : 0),
             int'($urandom_range(0, 4)));
    end
    repeat (12) @(negedge clk);
    finish_run();
  end
endmodule